// File: doc/BRIEF.md
# Global-History Concatenated-Index Branch Direction Predictor

This block predicts whether a conditional branch is taken. It keeps a table of 2-bit saturating counters and a shift register of recent resolved outcomes. The table index is built from two parts. The recent outcomes from the shift register fill the upper index bits. Address bits from the branch fill the lower index bits. The address is first shifted right past its guaranteed-zero low bits. Unlike a hashed scheme, the two parts are placed side by side and are never XORed together.

Every request carries a branch address and that branch's resolved direction. In the same cycle the block forms the index, reads the counter and derives a prediction. At the clock edge it registers the prediction and a mispredict flag, steps the counter toward the resolved direction, and shifts the outcome into the history. The response appears one cycle after its request. One request can be accepted every clock.

The production sizing is seven history bits and seven address bits, which gives 16384 counters. The defaults are smaller, so that the table elaborates at 1024 entries.

Top module: `gh_cat_dir_pred`

## Requirements
- R1: After a synchronous active-high reset, the response outputs are all 0. Every counter and the history are 0, so the first prediction for any address is not-taken.
- R2: The counter index is {history[HIST_BITS-1:0], pc[ADDR_SHIFT +: ADDR_BITS]}, with the history in the high bits. Address bits at or above ADDR_SHIFT+ADDR_BITS do not change the prediction.
- R3: The prediction is taken (rsp_pred_taken=1) when the indexed counter holds 2 or 3. It is not-taken when the counter holds 0 or 1.
- R4: rsp_mispred is 1 exactly when the registered prediction differs from the resolved direction of that request.
- R5: The index is formed from the history as it stood before the request. After the request the history shifts left by one, and the resolved outcome (1 = taken) enters bit 0.
- R6: A taken outcome increments the indexed counter. A counter already at 3 stays at 3.
- R7: A not-taken outcome decrements the indexed counter. A counter already at 0 stays at 0.
- R8: rsp_vld is 1 in the cycle after a request and 0 otherwise. A cycle without req_vld changes neither the history nor any counter.
- R9: Back-to-back requests to the same index see the counter value left by the request in the previous cycle.
- R10: The ADDR_SHIFT lowest address bits (default 2) do not affect the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request strobe, one branch per cycle |
| req_pc | input | PC_W (32) | Branch instruction address |
| req_taken | input | 1 | Resolved direction, 1 = taken |
| rsp_vld | output | 1 | Response valid, one cycle after req_vld |
| rsp_pred_taken | output | 1 | Predicted direction for that request |
| rsp_mispred | output | 1 | 1 when the prediction was wrong |

## Verification
The bench drives the history to all ones and then hits one counter on four consecutive cycles. A design that fails to forward updates, or that saturates wrongly, would show the wrong taken/not-taken step at that point. Idle cycles with req_taken held low are placed between requests; a design that shifts history without a request would lose a learned prediction there. The bench also changes address bits below the shift and above the index field, which a misplaced address slice would turn into a prediction change. After a single not-taken outcome, the same address is predicted again under a different history. A design that used the post-shift history, or that put history in the wrong index half, would either read the wrong counter or update it.

// File: rtl/bp_dir_pkg.sv
package bp_dir_pkg;

   typedef logic [1:0] ctr2_t;

   localparam ctr2_t CTR_HI = 2'd3;
   localparam ctr2_t CTR_LO = 2'd0;

   // one saturating step toward the resolved direction
   function automatic ctr2_t ctr_step(input ctr2_t cur, input logic up);
      ctr2_t res;
      if (up) res = (cur == CTR_HI) ? cur : ctr2_t'(cur + 2'd1);
      else    res = (cur == CTR_LO) ? cur : ctr2_t'(cur - 2'd1);
      return res;
   endfunction

   // upper half of the counter range means taken
   function automatic logic ctr_says_taken(input ctr2_t cur);
      return cur[1];
   endfunction

endpackage

// File: rtl/bp_index_gen.sv
module bp_index_gen #(
   parameter int PC_W       = 32,
   parameter int ADDR_SHIFT = 2,
   parameter int HIST_BITS  = 5,
   parameter int ADDR_BITS  = 5,
   localparam int IDX_W     = HIST_BITS + ADDR_BITS
) (
   input  logic [PC_W-1:0]      pc,
   input  logic [HIST_BITS-1:0] hist,
   output logic [IDX_W-1:0]     idx
);

   logic [ADDR_BITS-1:0] pc_field;

   generate
      if (ADDR_SHIFT == 0) begin : g_no_shift
         assign pc_field = pc[ADDR_BITS-1:0];
      end else begin : g_shift
         assign pc_field = pc[ADDR_SHIFT +: ADDR_BITS];
      end
   endgenerate

   assign idx = {hist, pc_field};

endmodule

// File: rtl/bp_hist_reg.sv
module bp_hist_reg #(
   parameter int HIST_BITS = 5
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 shift_en,
   input  logic                 bit_in,
   output logic [HIST_BITS-1:0] hist_q
);

   always_ff @(posedge clk) begin
      if (rst)           hist_q <= '0;
      else if (shift_en) hist_q <= {hist_q[HIST_BITS-2:0], bit_in};
   end

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
   import bp_dir_pkg::*;
#(
   parameter int IDX_W  = 10,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] rd_idx,
   output ctr2_t            rd_ctr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  ctr2_t            wr_ctr
);

   ctr2_t ctr_q [DEPTH];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_ent
         always_ff @(posedge clk) begin
            if (rst)
               ctr_q[e] <= CTR_LO;
            else if (wr_en && (wr_idx == IDX_W'(e)))
               ctr_q[e] <= wr_ctr;
         end
      end
   endgenerate

   // Writes land at the edge closing a request, so the next request's
   // read already sees them; no bypass path is required.
   assign rd_ctr = ctr_q[rd_idx];

endmodule

// File: rtl/gh_cat_dir_pred.sv
module gh_cat_dir_pred
   import bp_dir_pkg::*;
#(
   parameter int PC_W       = 32,
   parameter int ADDR_SHIFT = 2,
   parameter int HIST_BITS  = 5,
   parameter int ADDR_BITS  = 5
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            req_vld,
   input  logic [PC_W-1:0] req_pc,
   input  logic            req_taken,
   output logic            rsp_vld,
   output logic            rsp_pred_taken,
   output logic            rsp_mispred
);

   localparam int IDX_W = HIST_BITS + ADDR_BITS;

   generate
      if (ADDR_SHIFT < 0 || ADDR_SHIFT > 2) begin : g_bad_shift
         $error("ADDR_SHIFT must be 0, 1 or 2");
      end
      if (HIST_BITS < 2) begin : g_bad_hist
         $error("HIST_BITS must be at least 2");
      end
      if (ADDR_BITS < 1) begin : g_bad_addr
         $error("ADDR_BITS must be at least 1");
      end
      if (ADDR_SHIFT + ADDR_BITS > PC_W) begin : g_bad_pc
         $error("address field exceeds PC_W");
      end
   endgenerate

   logic [HIST_BITS-1:0] hist_q;
   logic [IDX_W-1:0]     idx;
   ctr2_t                rd_ctr;
   ctr2_t                nxt_ctr;
   logic                 pred_now;

   bp_index_gen #(
      .PC_W      (PC_W),
      .ADDR_SHIFT(ADDR_SHIFT),
      .HIST_BITS (HIST_BITS),
      .ADDR_BITS (ADDR_BITS)
   ) u_idx (
      .pc  (req_pc),
      .hist(hist_q),
      .idx (idx)
   );

   bp_ctr_table #(
      .IDX_W(IDX_W)
   ) u_tbl (
      .clk   (clk),
      .rst   (rst),
      .rd_idx(idx),
      .rd_ctr(rd_ctr),
      .wr_en (req_vld),
      .wr_idx(idx),
      .wr_ctr(nxt_ctr)
   );

   bp_hist_reg #(
      .HIST_BITS(HIST_BITS)
   ) u_hist (
      .clk     (clk),
      .rst     (rst),
      .shift_en(req_vld),
      .bit_in  (req_taken),
      .hist_q  (hist_q)
   );

   assign pred_now = ctr_says_taken(rd_ctr);
   assign nxt_ctr  = ctr_step(rd_ctr, req_taken);

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_vld        <= 1'b0;
         rsp_pred_taken <= 1'b0;
         rsp_mispred    <= 1'b0;
      end else begin
         rsp_vld        <= req_vld;
         rsp_pred_taken <= req_vld & pred_now;
         rsp_mispred    <= req_vld & (pred_now ^ req_taken);
      end
   end

endmodule

// File: rtl/gh_cat_dir_pred_chk.sv
module gh_cat_dir_pred_chk #(
   parameter int HIST_BITS = 5
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 req_vld,
   input logic                 req_taken,
   input logic                 rsp_vld,
   input logic                 rsp_pred_taken,
   input logic                 rsp_mispred,
   input logic [HIST_BITS-1:0] hist_q
);

   // R1: the cycle after reset shows no response
   p_quiet_after_reset_r1: assert property (@(posedge clk)
      $past(rst) |-> (!rsp_vld && !rsp_pred_taken && !rsp_mispred));

   // R4: the mispredict flag agrees with the prediction and the resolved direction
   p_mispred_rel_r4: assert property (@(posedge clk) disable iff (rst)
      rsp_vld |-> (rsp_mispred == (rsp_pred_taken ^ $past(req_taken))));

   // R5: the resolved outcome appears in the newest history bit
   p_hist_lsb_r5: assert property (@(posedge clk) disable iff (rst)
      req_vld |=> (hist_q[0] == $past(req_taken)));

   // R8: the response follows the request by one cycle
   p_rsp_follows_r8: assert property (@(posedge clk) disable iff (rst)
      req_vld |=> rsp_vld);

   // R8: an idle cycle produces no response
   p_no_rsp_idle_r8: assert property (@(posedge clk) disable iff (rst)
      !req_vld |=> (!rsp_vld && !rsp_pred_taken && !rsp_mispred));

   // R8: an idle cycle leaves the history alone
   p_hist_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !req_vld |=> $stable(hist_q));

endmodule

bind gh_cat_dir_pred gh_cat_dir_pred_chk #(
   .HIST_BITS(HIST_BITS)
) u_chk (
   .clk           (clk),
   .rst           (rst),
   .req_vld       (req_vld),
   .req_taken     (req_taken),
   .rsp_vld       (rsp_vld),
   .rsp_pred_taken(rsp_pred_taken),
   .rsp_mispred   (rsp_mispred),
   .hist_q        (hist_q)
);

// File: tb/gh_cat_dir_pred_tb_top.sv
`timescale 1ns/1ps
module gh_cat_dir_pred_tb_top;

   localparam int HB    = 5;
   localparam int AB    = 5;
   localparam int SH    = 2;
   localparam int NIDX  = 1 << (HB + AB);
   localparam int NSTIM = 24;

   // each entry: {pc[31:0], taken}
   localparam logic [32:0] STIM [NSTIM] = '{
      {32'h0000_0100, 1'b1}, {32'h0000_0100, 1'b1}, {32'h0000_0100, 1'b1},
      {32'h0000_0100, 1'b1}, {32'h0000_0100, 1'b1}, {32'h0000_0100, 1'b1},
      {32'h0000_0100, 1'b1}, {32'h0000_0100, 1'b1}, {32'h0000_0104, 1'b0},
      {32'h0000_0104, 1'b0}, {32'h0000_0104, 1'b0}, {32'h0000_0104, 1'b0},
      {32'h0000_0200, 1'b1}, {32'h0000_0200, 1'b0}, {32'h0000_0200, 1'b1},
      {32'h0000_0200, 1'b0}, {32'h0000_0100, 1'b0}, {32'h0000_0100, 1'b0},
      {32'h0000_0100, 1'b0}, {32'h0000_017C, 1'b1}, {32'h0000_017C, 1'b1},
      {32'h0000_017C, 1'b1}, {32'h8000_007C, 1'b1}, {32'h0000_0100, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_vld = 1'b0;
   logic [31:0] req_pc = '0;
   logic        req_taken = 1'b0;
   logic        rsp_vld, rsp_pred_taken, rsp_mispred;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   int          mdl_ctr [NIDX];
   logic [HB-1:0] mdl_hist;

   always #4 clk = ~clk;

   gh_cat_dir_pred dut_i (
      .clk           (clk),
      .rst           (rst),
      .req_vld       (req_vld),
      .req_pc        (req_pc),
      .req_taken     (req_taken),
      .rsp_vld       (rsp_vld),
      .rsp_pred_taken(rsp_pred_taken),
      .rsp_mispred   (rsp_mispred)
   );

   task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: {vld,pred,misp} actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // drive one request at a falling edge, read its response at the next falling edge
   task automatic send(input logic [31:0] pc, input logic tk,
                       input logic ep, input logic em, input string tag);
      req_vld = 1'b1; req_pc = pc; req_taken = tk;
      @(negedge clk);
      chk(tag, {rsp_vld, rsp_pred_taken, rsp_mispred}, {1'b1, ep, em});
   endtask

   task automatic idle(input string tag);
      req_vld = 1'b0; req_taken = 1'b0; req_pc = 32'hFFFF_FFFF;
      @(negedge clk);
      chk(tag, {rsp_vld, rsp_pred_taken, rsp_mispred}, 3'b000);
   endtask

   task automatic do_reset();
      req_vld = 1'b0;
      rst = 1'b1;
      @(negedge clk); @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      // R1: outputs cleared under reset
      chk("R1 reset outputs", {rsp_vld, rsp_pred_taken, rsp_mispred}, 3'b000);
      rst = 1'b0;

      // vector walk against a counter/history model built from R2..R7
      for (int i = 0; i < NIDX; i++) mdl_ctr[i] = 0;
      mdl_hist = '0;
      for (int v = 0; v < NSTIM; v++) begin
         logic [31:0] pc;
         logic        tk;
         logic        ep;
         int          ix;
         pc = STIM[v][32:1];
         tk = STIM[v][0];
         ix = int'({mdl_hist, pc[SH +: AB]});
         ep = (mdl_ctr[ix] >= 2);
         send(pc, tk, ep, ep ^ tk, "R2 R3 R4 R5 vector walk");
         if (tk && mdl_ctr[ix] < 3) mdl_ctr[ix]++;
         if (!tk && mdl_ctr[ix] > 0) mdl_ctr[ix]--;
         mdl_hist = {mdl_hist[HB-2:0], tk};
      end
      idle("R8 idle after walk");

      // directed corner cases from a clean state
      do_reset();
      send(32'h40, 1'b0, 1'b0, 1'b0, "R1 first prediction not-taken");
      send(32'h40, 1'b0, 1'b0, 1'b0, "R7 floor at 0");
      // fill history with ones using a different address field
      send(32'h20, 1'b1, 1'b0, 1'b1, "R4 taken vs not-taken");
      send(32'h20, 1'b1, 1'b0, 1'b1, "R5 fresh index per history");
      send(32'h20, 1'b1, 1'b0, 1'b1, "R5 fresh index per history");
      send(32'h20, 1'b1, 1'b0, 1'b1, "R5 fresh index per history");
      send(32'h20, 1'b1, 1'b0, 1'b1, "R5 fresh index per history");
      // history now all ones: train one counter on consecutive cycles
      send(32'h40, 1'b1, 1'b0, 1'b1, "R9 count 0->1");
      send(32'h40, 1'b1, 1'b0, 1'b1, "R9 count 1->2");
      send(32'h40, 1'b1, 1'b1, 1'b0, "R3 R9 count 2 predicts taken");
      send(32'h40, 1'b1, 1'b1, 1'b0, "R6 count 3");
      send(32'h40, 1'b1, 1'b1, 1'b0, "R6 ceiling at 3");
      idle("R8 no response when idle");
      send(32'h41, 1'b1, 1'b1, 1'b0, "R8 R10 low bits ignored, history kept");
      send(32'hC0, 1'b1, 1'b1, 1'b0, "R2 upper address bits ignored");
      send(32'h40, 1'b0, 1'b1, 1'b1, "R4 mispredict on not-taken");
      send(32'h40, 1'b1, 1'b0, 1'b1, "R5 history selects another counter");
      // rebuild all-ones history
      send(32'h20, 1'b1, 1'b0, 1'b1, "R5 rebuild history");
      send(32'h20, 1'b1, 1'b0, 1'b1, "R5 rebuild history");
      send(32'h20, 1'b1, 1'b0, 1'b1, "R5 rebuild history");
      send(32'h20, 1'b1, 1'b0, 1'b1, "R6 count 1 still not-taken");
      send(32'h20, 1'b1, 1'b0, 1'b1, "R5 rebuild history");
      send(32'h40, 1'b1, 1'b1, 1'b0, "R5 update used pre-shift index, count 2");
      send(32'h40, 1'b0, 1'b1, 1'b1, "R3 count 3 predicts taken");
      idle("R8 idle at end");

      do_reset();
      chk("R1 outputs after second reset", {rsp_vld, rsp_pred_taken, rsp_mispred}, 3'b000);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule